// File: doc/BRIEF.md
# Peripheral Register Write-Protection Controller

This block keeps firmware from changing peripheral configuration registers by accident. It holds two lock-bit registers. Each bit protects one whole group of peripherals, not a single peripheral. A set bit tells that group to drop every incoming register write. Reads of the group's registers always go through. The block drives a drop flag for each group, and it also returns each group's write strobe with the drop already applied.

The lock-bit registers are normally closed to change. Firmware opens them by writing two key bytes in order to a key register. Once they are open, the lock bits can be rewritten any number of times. The next write to the key register closes them again, whatever value it carries. Reading the key register shows whether the lock registers are closed and how far the key sequence has got.

Top module: `periph_lock_ctrl`

## Requirements
- R1: After reset, the key register reads 1 (closed, progress 0), both lock-bit registers read 0, and every bit of `grp_drop` is 0.
- R2: The key register is at word address 0. Only bits 7:0 of a key write are compared. Writing 0xA5 and then 0xF1 opens the lock registers. After the first byte the key register reads 3 (bit 0 = 1 closed, bits 2:1 = progress 1). After the second byte it reads 4 (bit 0 = 0 open, bits 2:1 = progress 2).
- R3: A wrong byte at either step returns the progress to 0 and the key register reads 1. This includes a second 0xA5 at step two. Progress is not carried over.
- R4: While the lock registers are open, any write to the key register closes them and sets the progress to 0. This holds even when the value is 0xA5.
- R5: While the lock registers are closed, writes to address 1 or 2 have no effect. The stored lock bits, their readback and `grp_drop` all stay unchanged.
- R6: While the lock registers are open, a write to address 1 stores the low N_A data bits and a write to address 2 stores the low N_B data bits. Readback is zero-extended. `grp_drop[N_A-1:0]` follows address 1 and `grp_drop[N_A+N_B-1:N_A]` follows address 2, starting in the cycle after the write.
- R7: `grp_wr_out[i]` is `grp_wr_in[i]` when `grp_drop[i]` is 0, and is 0 otherwise. The path is combinational.
- R8: `grp_rd_out` always equals `grp_rd_in`, whatever the lock bits are.
- R9: Writes to the lock-bit registers neither advance nor reset the key progress. Any other address reads 0, and writes to it have no effect.
- R10: Closing the lock registers keeps the lock bits that were last stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| grp_wr_in | input | N_A+N_B | Write strobes arriving for each peripheral group |
| grp_rd_in | input | N_A+N_B | Read strobes arriving for each peripheral group |
| grp_drop | output | N_A+N_B | 1 where a group must ignore writes |
| grp_wr_out | output | N_A+N_B | Write strobes after gating |
| grp_rd_out | output | N_A+N_B | Read strobes, passed through unchanged |

## Verification
The bench builds the block with N_A = 5 and N_B = 3, on a 32-bit data bus with a 4-bit address. Each lock register is then much narrower than the data word, so a write of all ones shows whether the upper bits are discarded and the readback is zero-extended. The split between the two registers inside `grp_drop` sits at an uneven bit position, which exposes an off-by-one in the slicing. The wide address leaves unmapped addresses, which are used to check that stray writes and reads have no effect.

// File: rtl/periph_lock_pkg.sv
`timescale 1ns/1ps
package periph_lock_pkg;
    localparam int KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'hF1;

    localparam int REG_KEY    = 0;
    localparam int REG_LOCK_A = 1;
    localparam int REG_LOCK_B = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HALF = 2'd1,
        SEQ_OPEN = 2'd2
    } seq_e;

    typedef struct packed {
        seq_e st;
    } seq_s;
endpackage

// File: rtl/periph_lock_seq.sv
`timescale 1ns/1ps
module periph_lock_seq
    import periph_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_val,
    output logic             open,
    output logic [1:0]       progress
);
    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (key_we) begin
            case (seq_q.st)
                SEQ_IDLE: seq_d.st = (key_val == KEY_FIRST)  ? SEQ_HALF : SEQ_IDLE;
                SEQ_HALF: seq_d.st = (key_val == KEY_SECOND) ? SEQ_OPEN : SEQ_IDLE;
                default:  seq_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q.st <= SEQ_IDLE;
        else        seq_q    <= seq_d;
    end

    assign open     = (seq_q.st == SEQ_OPEN);
    assign progress = seq_q.st;
endmodule

// File: rtl/periph_lock_reg.sv
`timescale 1ns/1ps
module periph_lock_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         open,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] bits
);
    logic [W-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (wr_en && open) bits_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits = bits_q;
endmodule

// File: rtl/periph_lock_gate.sv
`timescale 1ns/1ps
module periph_lock_gate #(
    parameter int NG = 16
) (
    input  logic [NG-1:0] lock,
    input  logic [NG-1:0] wr_in,
    input  logic [NG-1:0] rd_in,
    output logic [NG-1:0] drop,
    output logic [NG-1:0] wr_out,
    output logic [NG-1:0] rd_out
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign drop[g]   = lock[g];
        assign wr_out[g] = wr_in[g] & ~lock[g];
        assign rd_out[g] = rd_in[g];
    end
endmodule

// File: rtl/periph_lock_ctrl.sv
`timescale 1ns/1ps
module periph_lock_ctrl
    import periph_lock_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int N_A    = 8,
    parameter int N_B    = 8,
    localparam int NG    = N_A + N_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NG-1:0]     grp_wr_in,
    input  logic [NG-1:0]     grp_rd_in,
    output logic [NG-1:0]     grp_drop,
    output logic [NG-1:0]     grp_wr_out,
    output logic [NG-1:0]     grp_rd_out
);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(REG_KEY);
    localparam logic [ADDR_W-1:0] A_LCKA = ADDR_W'(REG_LOCK_A);
    localparam logic [ADDR_W-1:0] A_LCKB = ADDR_W'(REG_LOCK_B);

    logic           seq_open;
    logic [1:0]     seq_prog;
    logic [N_A-1:0] lock_a;
    logic [N_B-1:0] lock_b;

    logic sel_key, sel_a, sel_b;
    assign sel_key = (bus_addr == A_KEY);
    assign sel_a   = (bus_addr == A_LCKA);
    assign sel_b   = (bus_addr == A_LCKB);

    periph_lock_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (bus_we && sel_key),
        .key_val  (bus_wdata[KEY_W-1:0]),
        .open     (seq_open),
        .progress (seq_prog)
    );

    periph_lock_reg #(.W(N_A)) u_reg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && sel_a),
        .open  (seq_open),
        .wdata (bus_wdata[N_A-1:0]),
        .bits  (lock_a)
    );

    periph_lock_reg #(.W(N_B)) u_reg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && sel_b),
        .open  (seq_open),
        .wdata (bus_wdata[N_B-1:0]),
        .bits  (lock_b)
    );

    periph_lock_gate #(.NG(NG)) u_gate (
        .lock   ({lock_b, lock_a}),
        .wr_in  (grp_wr_in),
        .rd_in  (grp_rd_in),
        .drop   (grp_drop),
        .wr_out (grp_wr_out),
        .rd_out (grp_rd_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_key)    bus_rdata = DATA_W'({seq_prog, ~seq_open});
        else if (sel_a) bus_rdata = DATA_W'(lock_a);
        else if (sel_b) bus_rdata = DATA_W'(lock_b);
    end
endmodule

// File: rtl/periph_lock_chk.sv
`timescale 1ns/1ps
module periph_lock_chk #(
    parameter int ADDR_W = 4,
    parameter int NG     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        key_val,
    input logic [NG-1:0]     grp_drop,
    input logic [NG-1:0]     grp_wr_in,
    input logic [NG-1:0]     grp_wr_out,
    input logic [NG-1:0]     grp_rd_in,
    input logic [NG-1:0]     grp_rd_out,
    input logic              open,
    input logic [1:0]        progress
);
    logic past_ok;
    logic key_wr;
    assign key_wr = bus_we && (bus_addr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RELOCK_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && open) |=> !open);  // R4
    AST_OPEN_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && open && !$past(open)) |-> ($past(progress) == 2'd1 && $past(key_wr)));  // R2
    AST_WRONG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && progress == 2'd1 && key_val != 8'hF1) |=> (progress == 2'd0));  // R3
    AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(open)) |-> $stable(grp_drop));  // R5
    AST_NO_DROPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_wr_out & grp_drop) == '0) && ((grp_wr_out & ~grp_wr_in) == '0));  // R7
    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        grp_rd_out == grp_rd_in);  // R8
endmodule

bind periph_lock_ctrl periph_lock_chk #(.ADDR_W(ADDR_W), .NG(NG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .key_val    (bus_wdata[7:0]),
    .grp_drop   (grp_drop),
    .grp_wr_in  (grp_wr_in),
    .grp_wr_out (grp_wr_out),
    .grp_rd_in  (grp_rd_in),
    .grp_rd_out (grp_rd_out),
    .open       (seq_open),
    .progress   (seq_prog)
);

// File: tb/periph_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module periph_lock_ctrl_tb_top;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NA = 5;
    localparam int NB = 3;
    localparam int NG = NA + NB;
    localparam time CLK_P = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NG-1:0] grp_wr_in = '0;
    logic [NG-1:0] grp_rd_in = '0;
    logic [NG-1:0] grp_drop, grp_wr_out, grp_rd_out;

    always #(CLK_P/2) clk = ~clk;

    periph_lock_ctrl #(.ADDR_W(AW), .DATA_W(DW), .N_A(NA), .N_B(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_wr_in(grp_wr_in), .grp_rd_in(grp_rd_in), .grp_drop(grp_drop),
        .grp_wr_out(grp_wr_out), .grp_rd_out(grp_rd_out)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 drop, 2 wr_out, 3 rd_out
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = 32'(grp_drop);
                2:       act = 32'(grp_wr_out);
                default: act = 32'(grp_rd_out);
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(posedge clk); #2;
        bus_addr = AW'(addr); bus_we = 1'b1; bus_wdata = data;
        @(posedge clk); #2;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_item(input int kind, input int addr, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        bus_addr = AW'(addr);
        sb.push_back('{kind, exp, tag});
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_P * 60000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 0, 32'h1, "R1 key status");
        expect_item(0, 1, 32'h0, "R1 lock A");
        expect_item(0, 2, 32'h0, "R1 lock B");
        expect_item(1, 0, 32'h0, "R1 drop");

        // R5 closed writes ignored
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        expect_item(0, 1, 32'h0, "R5 lock A unchanged");
        expect_item(0, 2, 32'h0, "R5 lock B unchanged");
        expect_item(1, 0, 32'h0, "R5 drop unchanged");

        // R2 unlock sequence
        wr(0, 32'h0000_00A5);
        expect_item(0, 0, 32'h3, "R2 after first byte");
        wr(0, 32'h0000_00F1);
        expect_item(0, 0, 32'h4, "R2 open");

        // R6 / R9 lock writes while open
        wr(1, 32'hFFFF_FFFF);
        expect_item(0, 1, 32'h1F, "R6 lock A truncated");
        expect_item(0, 0, 32'h4, "R9 lock write keeps open");
        wr(2, 32'h0000_0005);
        expect_item(0, 2, 32'h5, "R6 lock B");
        expect_item(1, 0, 32'hBF, "R6 drop mapping");

        // R7 / R8 gating
        grp_wr_in = 8'hFF; grp_rd_in = 8'hA5;
        expect_item(2, 0, 32'h40, "R7 gated writes");
        expect_item(3, 0, 32'hA5, "R8 reads pass");
        grp_wr_in = 8'h3C; grp_rd_in = 8'hFF;
        expect_item(2, 0, 32'h00, "R7 all blocked");
        expect_item(3, 0, 32'hFF, "R8 reads pass locked");

        // R4 relock with any value
        wr(0, 32'h0000_00A5);
        expect_item(0, 0, 32'h1, "R4 relocked");
        wr(1, 32'h0);
        expect_item(0, 1, 32'h1F, "R10 lock A kept");
        expect_item(1, 0, 32'hBF, "R10 drop kept");

        // R3 wrong bytes
        wr(0, 32'h0000_00A5);
        wr(0, 32'h0000_00A5);
        expect_item(0, 0, 32'h1, "R3 repeated first byte");
        wr(0, 32'h0000_0012);
        expect_item(0, 0, 32'h1, "R3 wrong first byte");
        wr(0, 32'h0000_00F1);
        expect_item(0, 0, 32'h1, "R3 second byte alone");
        wr(0, 32'h0000_00A5);
        wr(0, 32'hFFFF_FFF1);
        expect_item(0, 0, 32'h4, "R2 only low byte compared");

        // R9 other addresses and tracker isolation
        wr(0, 32'h0);
        wr(0, 32'h0000_00A5);
        wr(3, 32'h0000_00F1);
        wr(1, 32'h0);
        expect_item(0, 3, 32'h0, "R9 unmapped reads 0");
        expect_item(0, 0, 32'h3, "R9 tracker untouched");
        expect_item(0, 1, 32'h1F, "R5 half-open write ignored");
        wr(0, 32'h0000_00F1);
        expect_item(0, 0, 32'h4, "R2 open again");
        wr(1, 32'h0);
        wr(2, 32'h0);
        expect_item(1, 0, 32'h0, "R6 cleared");
        expect_item(2, 0, 32'h3C, "R7 writes pass");
        wr(0, 32'h0);
        expect_item(0, 0, 32'h1, "R4 final relock");

        @(posedge clk);
        @(negedge clk); #1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule